// File: doc/BRIEF.md
# Reset Cause and Debug-Lock Status Register

This block is an 8-bit status and control register that remembers which source brought the chip out of its most recent reset. It also holds one guarded bit that can switch off the on-chip debug port. Software reaches the register through a small bus: select, write enable, write data and read data. Reset sources report to the block as single-cycle event inputs: external pin, brown-out, watchdog and the debug-port reset. The power-on reset is the block's own asynchronous reset. A fuse input decides whether the debug port may be used at all.

Each flag is set by its own source and cleared when software writes a zero to it. A power-on reset leaves only the power-on flag set. The debug-disable bit is protected against stray writes. It takes a new value only when software writes the same value twice, with the second write arriving one to four cycles after the first. A lone write only opens the window. A write with a different value opens a new window for that value.

Top module: `reset_status_reg`

## Requirements
- R1: While `por_n` is low the register reads 0x01: only the power-on flag (bit 0) is set and the debug-disable bit is 0. After release it stays in that state until an event or a write changes it.
- R2: The read layout is fixed. Bit 7 is debug-disable, bit 4 the debug-port reset flag, bit 3 watchdog, bit 2 brown-out, bit 1 external and bit 0 power-on. Bits 6 and 5 always read 0, and writing 1 to them has no effect.
- R3: A one-cycle pulse on `ext_rst_evt`, `bor_evt`, `wdt_evt` or `dbg_rst_evt` sets only its own flag (bit 1, 2, 3 or 4). The other flags keep their values. The flag is visible in the cycle after the pulse.
- R4: A register write clears each flag whose write-data bit is 0 and leaves each flag whose write-data bit is 1 unchanged. If a source event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: `dbg_if_en` is 1 only when `fuse_dbg_en` is 1 and the debug-disable bit is 0.
- R6: A single write to the register never changes the debug-disable bit.
- R7: A second write 1 to 4 cycles after the first, with the same bit-7 value, loads that value into the debug-disable bit. The new value is visible in the cycle after the second write.
- R8: A second write 5 or more cycles after the first does not change the debug-disable bit. It opens a fresh window instead, so a matching write in the next cycle completes the change.
- R9: A write whose bit 7 differs from the pending value does not change the debug-disable bit. It restarts the window with its own value and its own 4-cycle count.
- R10: With `sel` low, `rdata` is 0 and `wr_en` has no effect on any flag or on the debug-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sel | input | 1 | Register select for read and write |
| wr_en | input | 1 | Write strobe, effective with `sel` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| fuse_dbg_en | input | 1 | Fuse permitting the debug port |
| ext_rst_evt | input | 1 | External-pin reset event pulse |
| bor_evt | input | 1 | Brown-out reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| dbg_rst_evt | input | 1 | Debug-port reset event pulse |
| dbg_if_en | output | 1 | Debug port enable |
| rst_flags | output | 5 | Flags: [0] power-on, [1] external, [2] brown-out, [3] watchdog, [4] debug-port reset |

## Verification
The assertions assume that the event inputs, `sel`, `wr_en` and `wdata` are synchronous to `clk`. They also assume that `por_n` is released between clock edges, so no property sees a half-reset cycle. The bench changes every input on the falling clock edge and releases reset the same way. It counts write spacing in whole cycles, so each window test lands exactly on gap 1, 4 or 5. Each event pulse is one cycle wide, which the event-sets-flag property relies on to see the flag in the next cycle.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 5;
    localparam int DIS_BIT   = 7;
    localparam int IDX_POR   = 0;
    localparam int IDX_EXT   = 1;
    localparam int IDX_BOR   = 2;
    localparam int IDX_WDT   = 3;
    localparam int IDX_DBG   = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [REG_W-1:0]     reg_word_t;

    localparam flag_vec_t FLAGS_AT_POR = flag_vec_t'(1) << IDX_POR;
endpackage

// File: rtl/rsr_flag_bank.sv
module rsr_flag_bank
    import rsr_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      wr,
    input  flag_vec_t keep_mask,
    input  flag_vec_t evt,
    output flag_vec_t flags_q
);
    typedef struct packed {
        flag_vec_t flags;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            if (wr && !keep_mask[k]) st_d.flags[k] = 1'b0;
            if (evt[k])              st_d.flags[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q.flags <= FLAGS_AT_POR;
        else        st_q       <= st_d;
    end

    assign flags_q = st_q.flags;

    // R1: after reset the power-on flag can never be set again
    a_r1_por_flag_no_rise: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(flags_q[IDX_POR]));

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag_chk
        // R3: an event leaves its flag set
        a_r3_event_sets: assert property (@(posedge clk) disable iff (!por_n)
            evt[k] |=> flags_q[k]);
        // R4: a zero written without a competing event clears the flag
        a_r4_zero_clears: assert property (@(posedge clk) disable iff (!por_n)
            (wr && !keep_mask[k] && !evt[k]) |=> !flags_q[k]);
        // R4: a one written and no event leaves the flag unchanged
        a_r4_one_keeps: assert property (@(posedge clk) disable iff (!por_n)
            (wr && keep_mask[k] && !evt[k]) |=> $stable(flags_q[k]));
    end
endmodule

// File: rtl/rsr_timed_guard.sv
module rsr_timed_guard #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic wr,
    input  logic wbit,
    output logic dis_q
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic             val;
        logic [CNT_W-1:0] cnt;
        logic             dis;
    } guard_state_t;

    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
        if (wr) begin
            if (st_q.armed && (wbit == st_q.val)) begin
                st_d.dis   = wbit;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.armed = 1'b1;
                st_d.val   = wbit;
                st_d.cnt   = CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dis_q = st_q.dis;

    // R6: a write that only opens the window keeps the bit
    a_r6_single_write_holds: assert property (@(posedge clk) disable iff (!por_n)
        (wr && !st_q.armed) |=> $stable(dis_q));
    // R7: the bit moves only right after a write
    a_r7_change_needs_write: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(dis_q) |-> $past(wr));
    // R8: the window count never passes its limit
    a_r8_window_bounded: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt <= CNT_LAST);
    // R9: a mismatching write keeps the bit
    a_r9_mismatch_holds: assert property (@(posedge clk) disable iff (!por_n)
        (wr && st_q.armed && (wbit != st_q.val)) |=> $stable(dis_q));
endmodule

// File: rtl/reset_status_reg.sv
module reset_status_reg
    import rsr_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sel,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        fuse_dbg_en,
    input  logic        ext_rst_evt,
    input  logic        bor_evt,
    input  logic        wdt_evt,
    input  logic        dbg_rst_evt,
    output logic        dbg_if_en,
    output logic [4:0]  rst_flags
);
    logic      wr;
    logic      dis;
    flag_vec_t flags;
    flag_vec_t evt;
    reg_word_t view;

    assign wr = sel & wr_en;

    always_comb begin
        evt          = '0;
        evt[IDX_EXT] = ext_rst_evt;
        evt[IDX_BOR] = bor_evt;
        evt[IDX_WDT] = wdt_evt;
        evt[IDX_DBG] = dbg_rst_evt;
    end

    rsr_flag_bank u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .wr        (wr),
        .keep_mask (wdata[NUM_FLAGS-1:0]),
        .evt       (evt),
        .flags_q   (flags)
    );

    rsr_timed_guard #(.WINDOW(WINDOW)) u_guard (
        .clk   (clk),
        .por_n (por_n),
        .wr    (wr),
        .wbit  (wdata[DIS_BIT]),
        .dis_q (dis)
    );

    always_comb begin
        view                  = '0;
        view[NUM_FLAGS-1:0]   = flags;
        view[DIS_BIT]         = dis;
    end

    assign rdata     = sel ? view : '0;
    assign dbg_if_en = fuse_dbg_en & ~dis;
    assign rst_flags = flags;

    // R5: a set disable bit always blocks the debug port
    a_r5_disabled_blocks: assert property (@(posedge clk) disable iff (!por_n)
        dis |-> !dbg_if_en);
    // R2: reserved bits read zero even right after ones are written there
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        (wr && (wdata[6:5] != 2'b00)) |=> (rdata[6:5] == 2'b00));
    // R10: an unselected strobe changes nothing
    a_r10_unselected_inert: assert property (@(posedge clk) disable iff (!por_n)
        (!sel && !ext_rst_evt && !bor_evt && !wdt_evt && !dbg_rst_evt) |=>
            ($stable(flags) && $stable(dis)));
endmodule

// File: tb/sim_reset_status_reg.sv
module sim_reset_status_reg;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fuse_dbg_en = 1'b1;
    logic       ext_rst_evt = 1'b0;
    logic       bor_evt = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       dbg_rst_evt = 1'b0;
    logic       dbg_if_en;
    logic [4:0] rst_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    reset_status_reg u0 (
        .clk(clk), .por_n(por_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .fuse_dbg_en(fuse_dbg_en), .ext_rst_evt(ext_rst_evt),
        .bor_evt(bor_evt), .wdt_evt(wdt_evt), .dbg_rst_evt(dbg_rst_evt),
        .dbg_if_en(dbg_if_en), .rst_flags(rst_flags)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        sel = 1'b1;
        #1;
        chk(req, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic en_chk(input string req, input logic exp);
        #1;
        chk(req, {7'd0, dbg_if_en}, {7'd0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        sel = 1'b1; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic pulse(input int src);
        case (src)
            1: ext_rst_evt = 1'b1;
            2: bor_evt     = 1'b1;
            3: wdt_evt     = 1'b1;
            default: dbg_rst_evt = 1'b1;
        endcase
        @(negedge clk);
        ext_rst_evt = 1'b0; bor_evt = 1'b0; wdt_evt = 1'b0; dbg_rst_evt = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 reset read", 8'h01);
        chk("R1 reset flags", {3'd0, rst_flags}, 8'h01);
        en_chk("R5 enabled after reset", 1'b1);
    endtask

    task automatic t_events;
        wr(8'h00);
        rd_chk("R4 write zero clears", 8'h00);
        idle(6);
        pulse(3); rd_chk("R3 watchdog bit3", 8'h08);
        pulse(1); rd_chk("R3 external bit1", 8'h0A);
        pulse(2); rd_chk("R3 brown-out bit2", 8'h0E);
        pulse(4); rd_chk("R3 debug reset bit4", 8'h1E);
        chk("R3 flags port", {3'd0, rst_flags}, 8'h1E);
    endtask

    task automatic t_write_rules;
        wr(8'h1F); rd_chk("R4 ones keep flags", 8'h1E);
        wr(8'h17); rd_chk("R4 clear watchdog only", 8'h16);
        wr(8'h76); rd_chk("R2 reserved bits ignored", 8'h16);
        sel = 1'b1; wr_en = 1'b1; wdata = 8'h00; bor_evt = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; bor_evt = 1'b0;
        rd_chk("R4 event beats clear", 8'h04);
        idle(6);
    endtask

    task automatic t_single;
        wr(8'h80); idle(6);
        rd_chk("R6 single write no change", 8'h00);
        en_chk("R6 still enabled", 1'b1);
    endtask

    task automatic t_pairs;
        wr(8'h80); rd_chk("R6 after first of pair", 8'h00);
        wr(8'h80); rd_chk("R7 gap 1 sets disable", 8'h80);
        en_chk("R5 disabled blocks port", 1'b0);
        idle(6);
        wr(8'h00); idle(3); wr(8'h00);
        rd_chk("R7 gap 4 clears disable", 8'h00);
        en_chk("R7 port back on", 1'b1);
        idle(6);
    endtask

    task automatic t_late;
        wr(8'h80); idle(4); wr(8'h80);
        rd_chk("R8 gap 5 rejected", 8'h00);
        wr(8'h80);
        rd_chk("R8 late write opened new window", 8'h80);
        idle(6); wr(8'h00); wr(8'h00);
        rd_chk("R7 restore clear", 8'h00);
        idle(6);
    endtask

    task automatic t_mismatch;
        wr(8'h00); wr(8'h80);
        rd_chk("R9 mismatch no change", 8'h00);
        idle(3); wr(8'h80);
        rd_chk("R9 restarted window accepts", 8'h80);
    endtask

    task automatic t_fuse;
        fuse_dbg_en = 1'b0;
        en_chk("R5 fuse off and disabled", 1'b0);
        idle(6); wr(8'h00); wr(8'h00);
        en_chk("R5 fuse off blocks", 1'b0);
        fuse_dbg_en = 1'b1;
        en_chk("R5 fuse on enables", 1'b1);
        idle(6);
    endtask

    task automatic t_unselected;
        pulse(3);
        sel = 1'b0; wr_en = 1'b1; wdata = 8'h80;
        @(negedge clk);
        #1;
        chk("R10 unselected write keeps flags", {3'd0, rst_flags}, 8'h08);
        chk("R10 rdata zero unselected", rdata, 8'h00);
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
        en_chk("R10 unselected writes no disable", 1'b1);
    endtask

    task automatic t_por_again;
        wr(8'h80); wr(8'h80); pulse(1);
        rd_chk("R7 set before power-on", 8'h82);
        por_n = 1'b0;
        @(negedge clk);
        rd_chk("R1 during power-on", 8'h01);
        por_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 after power-on", 8'h01);
        en_chk("R1 port enabled after power-on", 1'b1);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_events;
        t_write_rules;
        t_single;
        t_pairs;
        t_late;
        t_mismatch;
        t_fuse;
        t_unselected;
        t_por_again;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule